// File: doc/BRIEF.md
# Vector Byte Table Lookup Unit

This block builds a 128-bit result vector one byte at a time. Each byte of an index vector picks one byte out of a lookup table made of one to four consecutive 128-bit vectors. The selected bytes are packed into the result vector in the lane order of the index vector. The lanes are handled independently, so any permutation, duplication or broadcast of table bytes can be expressed.

An index can point past the end of the table. A single mode input then decides what that lane produces. In zeroing mode the lane becomes zero. In keeping mode the lane takes the matching byte of a supplied previous destination vector. Because the previous vector is an input, a table longer than four vectors can be covered in several passes.

The result is registered. It appears with a valid flag one clock after the request is presented, and it holds its value while no request arrives.

Top module: `vec_byte_lookup`

## Requirements
- R1: After reset `out_valid` is 0 and `out_vec` is all zeros. A cycle with `in_valid` high makes `out_valid` high on the next cycle.
- R2: Table byte k (0..15) of table vector r sits at flat index 16·r + k. Table vector r occupies `tbl_regs[128·r+127 : 128·r]`, and byte k of a vector occupies bits 8·k+7..8·k, so byte 0 is the lowest. An in-range index i in lane j gives result byte j equal to flat table byte i.
- R3: `tbl_len` encodes the table length as N−1, with codes 0..3 meaning 1..4 vectors. Indices 0 to 16·N−1 are in range, and index 16·N is the first index out of range.
- R4: When `keep_mode` is 0 (zeroing), a lane whose index is out of range yields 0x00.
- R5: When `keep_mode` is 1 (keeping), a lane whose index is out of range yields the byte of `old_vec` in the same lane.
- R6: An index is compared as an unsigned 8-bit value, so indices 0x80 to 0xFF are always out of range.
- R7: The 16 lanes are independent. Several lanes may use the same index, and each lane follows its own range decision.
- R8: Table vectors at position N and above have no effect on the result.
- R9: While `in_valid` is low, `out_valid` is 0 on the next cycle and `out_vec` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is present this cycle |
| tbl_regs | input | 512 | Up to four table vectors, vector 0 in the lowest bits |
| tbl_len | input | 2 | Number of table vectors minus one |
| idx_vec | input | 128 | One index byte per result lane |
| old_vec | input | 128 | Previous destination bytes, used in keeping mode |
| keep_mode | input | 1 | 0: out-of-range lanes become zero; 1: they keep the old byte |
| out_valid | output | 1 | Result registered from the previous cycle's request |
| out_vec | output | 128 | Result vector |

## Verification
The assertions assume that every request input is known and stable across the clock edge on which `in_valid` is sampled, and that `tbl_len` is a legal code for the configured table size. Under these assumptions the zero-fill, keep-old and identity properties can compare the output against the previous cycle's inputs. The stimulus changes inputs only on the falling edge and drops `in_valid` after each single-cycle request. It uses only the four legal length codes and places index values on both sides of each table boundary, including the top half of the byte range.

// File: rtl/vlu_pkg.sv
package vlu_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        OOB_ZERO = 1'b0,
        OOB_KEEP = 1'b1
    } oob_mode_e;

endpackage

// File: rtl/vlu_limit.sv
// Turns the length code into the count of addressable table bytes.
module vlu_limit #(
    parameter int VEC_BYTES = 16,
    parameter int MAX_REGS  = 4,
    parameter int LEN_W     = 2,
    parameter int CMP_W     = 9
) (
    input  logic [LEN_W-1:0] len_code,
    output logic [CMP_W-1:0] limit
);

    localparam int LAST_CODE = MAX_REGS - 1;

    logic [CMP_W-1:0] regs_used;

    always_comb begin
        // codes past the configured table size saturate at the full table
        if (int'(len_code) > LAST_CODE) begin
            regs_used = CMP_W'(MAX_REGS);
        end else begin
            regs_used = CMP_W'(len_code) + CMP_W'(1);
        end
        limit = regs_used * CMP_W'(VEC_BYTES);
    end

endmodule

// File: rtl/vlu_byte_mux.sv
// Picks one byte of the flat table by index; unmatched index yields zero.
module vlu_byte_mux
    import vlu_pkg::*;
#(
    parameter int TBL_BYTES = 64
) (
    input  logic [TBL_BYTES*BYTE_W-1:0] table_bytes,
    input  byte_t                       sel,
    output byte_t                       picked
);

    always_comb begin
        picked = '0;
        for (int k = 0; k < TBL_BYTES; k++) begin
            if (int'(sel) == k) begin
                picked = table_bytes[k*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/vlu_lane.sv
// One result lane: range test, table selection and out-of-range policy.
module vlu_lane
    import vlu_pkg::*;
#(
    parameter int TBL_BYTES = 64,
    parameter int CMP_W     = 9
) (
    input  logic [TBL_BYTES*BYTE_W-1:0] table_bytes,
    input  byte_t                       idx_byte,
    input  byte_t                       old_byte,
    input  logic [CMP_W-1:0]            limit,
    input  oob_mode_e                   mode,
    output byte_t                       res_byte
);

    logic  in_range;
    byte_t picked;

    vlu_byte_mux #(
        .TBL_BYTES(TBL_BYTES)
    ) u_mux (
        .table_bytes(table_bytes),
        .sel        (idx_byte),
        .picked     (picked)
    );

    always_comb begin
        in_range = CMP_W'(idx_byte) < limit;
        if (in_range) begin
            res_byte = picked;
        end else if (mode == OOB_KEEP) begin
            res_byte = old_byte;
        end else begin
            res_byte = '0;
        end
    end

endmodule

// File: rtl/vec_byte_lookup.sv
// Byte table lookup over one to MAX_REGS vectors, registered result.
module vec_byte_lookup
    import vlu_pkg::*;
#(
    parameter  int VEC_BYTES = 16,
    parameter  int MAX_REGS  = 4,
    localparam int VEC_W     = VEC_BYTES * BYTE_W,
    localparam int LEN_W     = (MAX_REGS > 1) ? $clog2(MAX_REGS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [MAX_REGS*VEC_W-1:0] tbl_regs,
    input  logic [LEN_W-1:0]          tbl_len,
    input  logic [VEC_W-1:0]          idx_vec,
    input  logic [VEC_W-1:0]          old_vec,
    input  logic                      keep_mode,
    output logic                      out_valid,
    output logic [VEC_W-1:0]          out_vec
);

    localparam int TBL_BYTES = VEC_BYTES * MAX_REGS;
    localparam int LIM_W     = $clog2(TBL_BYTES + 1);
    localparam int CMP_W     = ((LIM_W > BYTE_W) ? LIM_W : BYTE_W) + 1;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] data;
    } state_t;

    state_t           state_d;
    state_t           state_q;
    logic [CMP_W-1:0] limit;
    logic [VEC_W-1:0] lane_res;
    oob_mode_e        mode;

    assign mode = oob_mode_e'(keep_mode);

    vlu_limit #(
        .VEC_BYTES(VEC_BYTES),
        .MAX_REGS (MAX_REGS),
        .LEN_W    (LEN_W),
        .CMP_W    (CMP_W)
    ) u_limit (
        .len_code(tbl_len),
        .limit   (limit)
    );

    for (genvar j = 0; j < VEC_BYTES; j++) begin : g_lane
        vlu_lane #(
            .TBL_BYTES(TBL_BYTES),
            .CMP_W    (CMP_W)
        ) u_lane (
            .table_bytes(tbl_regs),
            .idx_byte   (idx_vec[j*BYTE_W +: BYTE_W]),
            .old_byte   (old_vec[j*BYTE_W +: BYTE_W]),
            .limit      (limit),
            .mode       (mode),
            .res_byte   (lane_res[j*BYTE_W +: BYTE_W])
        );
    end

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.data = lane_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign out_vec   = state_q.data;

endmodule

// File: rtl/vlu_checker.sv
module vlu_checker #(
    parameter int VEC_BYTES = 16,
    parameter int MAX_REGS  = 4,
    parameter int VEC_W     = 128,
    parameter int LEN_W     = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [MAX_REGS*VEC_W-1:0] tbl_regs,
    input logic [LEN_W-1:0]          tbl_len,
    input logic [VEC_W-1:0]          idx_vec,
    input logic [VEC_W-1:0]          old_vec,
    input logic                      keep_mode,
    input logic                      out_valid,
    input logic [VEC_W-1:0]          out_vec
);

    int   bound;
    logic all_oob;
    logic identity;

    always_comb begin
        bound    = ((int'(tbl_len) >= MAX_REGS) ? MAX_REGS : int'(tbl_len) + 1) * VEC_BYTES;
        all_oob  = 1'b1;
        identity = 1'b1;
        for (int j = 0; j < VEC_BYTES; j++) begin
            if (int'(idx_vec[j*8 +: 8]) < bound) all_oob = 1'b0;
            if (int'(idx_vec[j*8 +: 8]) != j)    identity = 1'b0;
        end
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_vec));

    // R4
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !keep_mode && all_oob) |=> (out_vec == '0));

    // R5
    keep_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && keep_mode && all_oob) |=> (out_vec == $past(old_vec)));

    // R2
    identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && identity) |=> (out_vec == $past(tbl_regs[VEC_W-1:0])));

endmodule

bind vec_byte_lookup vlu_checker #(
    .VEC_BYTES(VEC_BYTES),
    .MAX_REGS (MAX_REGS),
    .VEC_W    (VEC_W),
    .LEN_W    (LEN_W)
) u_vlu_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .tbl_regs (tbl_regs),
    .tbl_len  (tbl_len),
    .idx_vec  (idx_vec),
    .old_vec  (old_vec),
    .keep_mode(keep_mode),
    .out_valid(out_valid),
    .out_vec  (out_vec)
);

// File: tb/tb_vec_byte_lookup.sv
module tb_vec_byte_lookup;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] tbl_regs = '0;
    logic [1:0]   tbl_len = '0;
    logic [127:0] idx_vec = '0;
    logic [127:0] old_vec = '0;
    logic         keep_mode = 1'b0;
    logic         out_valid;
    logic [127:0] out_vec;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #2 clk = ~clk;

    vec_byte_lookup dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .tbl_regs(tbl_regs),
        .tbl_len(tbl_len), .idx_vec(idx_vec), .old_vec(old_vec),
        .keep_mode(keep_mode), .out_valid(out_valid), .out_vec(out_vec)
    );

    // Expected result from the requirements: flat index 16*r+k, limit 16*(code+1).
    function automatic logic [127:0] model(logic [511:0] t, logic [1:0] len,
                                           logic [127:0] idx, logic [127:0] old,
                                           logic keep);
        logic [127:0] r;
        int lim;
        lim = (int'(len) + 1) * 16;
        for (int j = 0; j < 16; j++) begin
            int i;
            i = int'(idx[j*8 +: 8]);
            if (i < lim)   r[j*8 +: 8] = t[i*8 +: 8];
            else if (keep) r[j*8 +: 8] = old[j*8 +: 8];
            else           r[j*8 +: 8] = 8'h00;
        end
        return r;
    endfunction

    function automatic logic [31:0] step(logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic rnd128(output logic [127:0] v);
        for (int w = 0; w < 4; w++) begin
            seed = step(seed);
            v[w*32 +: 32] = seed;
        end
    endtask

    task automatic rnd512(output logic [511:0] v);
        logic [127:0] p;
        for (int q = 0; q < 4; q++) begin
            rnd128(p);
            v[q*128 +: 128] = p;
        end
    endtask

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one request, result checked one cycle later
    task automatic run(string req, logic [511:0] t, logic [1:0] len,
                       logic [127:0] idx, logic [127:0] old, logic keep,
                       output logic [127:0] got);
        @(negedge clk);
        in_valid = 1'b1; tbl_regs = t; tbl_len = len;
        idx_vec = idx; old_vec = old; keep_mode = keep;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {127'b0, out_valid}, 128'd1);
        check(req, out_vec, model(t, len, idx, old, keep));
        got = out_vec;
    endtask

    task automatic t_reset();
        check("R1 reset valid", {127'b0, out_valid}, 128'd0);
        check("R1 reset data", out_vec, '0);
    endtask

    task automatic t_identity();
        logic [511:0] t; logic [127:0] idx, o, g;
        rnd512(t); rnd128(o);
        for (int j = 0; j < 16; j++) idx[j*8 +: 8] = 8'(j);
        run("R2 identity", t, 2'd0, idx, o, 1'b0, g);
        check("R2 identity equals vector0", g, t[127:0]);
        for (int j = 0; j < 16; j++) idx[j*8 +: 8] = 8'(15 - j);
        run("R2 reverse", t, 2'd0, idx, o, 1'b1, g);
    endtask

    task automatic t_lengths();
        logic [511:0] t; logic [127:0] idx, o, g;
        rnd512(t); rnd128(o);
        for (int n = 0; n < 4; n++) begin
            for (int j = 0; j < 16; j++) idx[j*8 +: 8] = 8'(j * 4 + 3);
            run("R3 span", t, 2'(n), idx, o, 1'(n & 1), g);
            // boundary: last valid and first invalid index per length
            for (int j = 0; j < 16; j++)
                idx[j*8 +: 8] = (j % 2 == 0) ? 8'(16*(n+1) - 1) : 8'(16*(n+1));
            run("R3 boundary", t, 2'(n), idx, o, 1'b0, g);
            check("R3 last valid byte", {120'b0, g[7:0]}, {120'b0, t[(16*(n+1)-1)*8 +: 8]});
            check("R4 first invalid zero", {120'b0, g[15:8]}, 128'd0);
        end
    endtask

    task automatic t_policies();
        logic [511:0] t; logic [127:0] idx, o, g;
        rnd512(t); rnd128(o);
        for (int j = 0; j < 16; j++) idx[j*8 +: 8] = 8'(40 + j);
        run("R4 all zero", t, 2'd1, idx, o, 1'b0, g);
        check("R4 zero result", g, '0);
        run("R5 all keep", t, 2'd1, idx, o, 1'b1, g);
        check("R5 keep result", g, o);
        for (int j = 0; j < 16; j++) idx[j*8 +: 8] = (j % 3 == 0) ? 8'(80 + j) : 8'(j * 2);
        run("R5 mixed keep", t, 2'd1, idx, o, 1'b1, g);
    endtask

    task automatic t_high_index();
        logic [511:0] t; logic [127:0] idx, o, g;
        rnd512(t); rnd128(o);
        for (int j = 0; j < 16; j++) idx[j*8 +: 8] = 8'h80 | 8'(j * 8);
        run("R6 high zero", t, 2'd3, idx, o, 1'b0, g);
        check("R6 high zero result", g, '0);
        run("R6 high keep", t, 2'd3, idx, o, 1'b1, g);
        check("R6 high keep result", g, o);
    endtask

    task automatic t_broadcast();
        logic [511:0] t; logic [127:0] idx, o, g;
        rnd512(t); rnd128(o);
        idx = {16{8'd37}};
        run("R7 broadcast", t, 2'd2, idx, o, 1'b0, g);
        check("R7 broadcast result", g, {16{t[37*8 +: 8]}});
    endtask

    task automatic t_unused();
        logic [511:0] t; logic [127:0] idx, o, g1, g2;
        rnd512(t); rnd128(o);
        for (int j = 0; j < 16; j++) idx[j*8 +: 8] = (j < 8) ? 8'(j * 2) : 8'(16 + j);
        run("R8 first", t, 2'd0, idx, o, 1'b0, g1);
        t[511:128] = ~t[511:128];
        run("R8 second", t, 2'd0, idx, o, 1'b0, g2);
        check("R8 unused vectors ignored", g2, g1);
    endtask

    task automatic t_hold();
        logic [511:0] t; logic [127:0] idx, o, g;
        rnd512(t); rnd128(o); rnd128(idx);
        run("R9 setup", t, 2'd3, idx, o, 1'b1, g);
        tbl_regs = ~t; idx_vec = ~idx; old_vec = ~o; keep_mode = 1'b0;
        @(negedge clk);
        check("R9 valid low", {127'b0, out_valid}, 128'd0);
        check("R9 data held", out_vec, g);
        @(negedge clk);
        check("R9 data still held", out_vec, g);
    endtask

    task automatic t_sweep();
        logic [511:0] t; logic [127:0] idx, o, g;
        for (int s = 0; s < 24; s++) begin
            rnd512(t); rnd128(o); rnd128(idx);
            for (int j = 0; j < 16; j++) idx[j*8 +: 8] = idx[j*8 +: 8] & 8'h4F;
            run("R2 R3 R4 R5 sweep", t, 2'(s % 4), idx, o, 1'(s / 4 % 2), g);
        end
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_identity();
        t_lengths();
        t_policies();
        t_high_index();
        t_broadcast();
        t_unused();
        t_hold();
        t_sweep();
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule